// File: doc/BRIEF.md
# Dual-Mode Host Register Interface

This block is the slave side of an 8-bit microprocessor port. Through it a host reads and writes a bank of eight byte-wide registers. A static strap input selects one of two bus conventions. Both conventions share the same two control pins. In the first convention, one pin is a data strobe that is high during the processor's active clock phase, and the other pin is a read/write level. In the second convention, the two pins are separate active-low read and write strobes.

Register 0 holds the interrupt causes. Four event inputs each set their own sticky bit in it. While any bit is set, an active-high interrupt line is asserted. When the host reads register 0, the bits it saw are cleared at the end of the read. A cause that arrives on the closing edge of that read survives. Registers 1 to 7 are plain read/write scratch bytes. The data bus is split into an input byte, an output byte and an output enable, so that a pad ring can build the bidirectional pin from them.

The host pins are sampled with the block clock. Each strobe phase must last at least one clock cycle.

Top module: `host_regif`

## Requirements
- R1: After reset, `irq` is low, `data_oe` is low, and every register reads as 0x00.
- R2: `data_oe` is high only while `cs_n` is low and a read is qualified, and `data_out` is 0x00 whenever `data_oe` is low. With `bus_style`=0 a read is qualified by `strb_a` high and `strb_b` high. With `bus_style`=1 it is qualified by `strb_a` low. Read data follows `addr` combinationally.
- R3: With `bus_style`=0, a write happens on the clock after `strb_a` falls, provided that in the previous cycle `strb_a` was high, `strb_b` was low and `cs_n` was low. The address and data written are the ones sampled in that previous cycle.
- R4: With `bus_style`=1, a write happens on the clock after `strb_b` rises, provided that in the previous cycle `strb_b` was low and `cs_n` was low. The address and data come from that previous cycle.
- R5: A strobe cycle with `cs_n` high writes nothing and drives nothing.
- R6: Registers 1 to 7 return the last byte written to them. Writes to register 0 are ignored.
- R7: In register 0, bit 0 is command done, bit 1 is DMA done, bit 2 is demodulation error and bit 3 is end-of-page code. These match `cause_in[0..3]`. Each bit is sticky, and bits 7:4 read as 0.
- R8: `irq` is high in the cycle after any `cause_in` bit is high. It stays high while any bit of register 0 is set.
- R9: When a read of register 0 ends, the bits shown in its last read cycle are cleared. Bits set after that cycle remain. If no bits remain, `irq` is low from the next cycle.
- R10: A cause that is high on the clock edge where a register 0 read ends is kept set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_style | input | 1 | 0: strobe plus R/W level, 1: separate RD/WR strobes |
| cs_n | input | 1 | Active-low chip select |
| strb_a | input | 1 | Data strobe (style 0) or active-low read (style 1) |
| strb_b | input | 1 | R/W level, high = read (style 0) or active-low write (style 1) |
| addr | input | 3 | Register select |
| data_in | input | 8 | Byte from host during writes |
| data_out | output | 8 | Byte to host during reads |
| data_oe | output | 1 | Pad output enable for the data bus |
| cause_in | input | 4 | Interrupt event pulses |
| irq | output | 1 | Active-high interrupt request |

## Verification
The scratch registers are loaded with distinct values in one bus style and read back in the other. This separates a wrong capture edge or a wrong capture sample from a wrong read decode. A write with chip select high, and writes to register 0, show that the gating and the read-only decode are in place. Interrupt causes are raised one at a time and in combinations, and each is read back to show the bit mapping and the clear-on-read. A cause raised on the very edge that ends a read tells apart a clear that masks only the bits shown from one that wipes the whole register.

// File: rtl/hrif_pkg.sv
package hrif_pkg;

    localparam int HRIF_ADDR_W  = 3;
    localparam int HRIF_DATA_W  = 8;
    localparam int HRIF_CAUSES  = 4;
    localparam int HRIF_IRR_IDX = 0;

    typedef enum logic {
        STYLE_STROBE_RW = 1'b0,
        STYLE_SPLIT_RW  = 1'b1
    } bus_style_e;

    // snapshot of the host control pins for one clock
    typedef struct packed {
        logic cs_n;
        logic pin_a;
        logic pin_b;
    } ctl_pins_t;

    function automatic logic read_qualified(bus_style_e st, ctl_pins_t p);
        if (st == STYLE_STROBE_RW)
            return !p.cs_n && p.pin_a && p.pin_b;
        else
            return !p.cs_n && !p.pin_a;
    endfunction

    function automatic logic write_closing(bus_style_e st, ctl_pins_t prev, ctl_pins_t cur);
        if (st == STYLE_STROBE_RW)
            return !prev.cs_n && prev.pin_a && !prev.pin_b && !cur.pin_a;
        else
            return !prev.cs_n && !prev.pin_b && cur.pin_b;
    endfunction

endpackage

// File: rtl/hrif_strobe_decode.sv
module hrif_strobe_decode
    import hrif_pkg::*;
#(
    parameter int AW = HRIF_ADDR_W,
    parameter int DW = HRIF_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_style_e    style,
    input  ctl_pins_t     pins,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_act,
    output logic          rd_end,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    ctl_pins_t     pins_q;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '{cs_n: 1'b1, pin_a: 1'b0, pin_b: 1'b1};
            rd_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            pins_q <= pins;
            rd_q   <= rd_act;
            addr_q <= addr;
            data_q <= wdata;
        end
    end

    always_comb begin
        rd_act  = read_qualified(style, pins);
        rd_end  = rd_q && !rd_act;
        wr_fire = write_closing(style, pins_q, pins);
        wr_addr = addr_q;
        wr_data = data_q;
    end

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

    // R5
    wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> $past(!pins.cs_n));

endmodule

// File: rtl/hrif_scratch.sv
module hrif_scratch #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] mem [1:NREG-1];

    for (genvar i = 1; i < NREG; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_en && wr_addr == AW'(i))
                mem[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 1; k < NREG; k++)
            if (rd_addr == AW'(k)) rd_data = mem[k];
    end

    // R6
    scratch_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/hrif_irq_status.sv
module hrif_irq_status #(
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] cause_in,
    input  logic          rd_sel,
    input  logic          rd_end,
    output logic [NC-1:0] status,
    output logic          irq
);

    logic [NC-1:0] pend;
    logic [NC-1:0] shown;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            shown <= '0;
            seen  <= 1'b0;
        end else begin
            if (rd_sel) begin
                shown <= pend;
                seen  <= 1'b1;
            end
            if (rd_end && seen) begin
                pend <= (pend & ~shown) | cause_in;
                seen <= 1'b0;
            end else begin
                pend <= pend | cause_in;
            end
        end
    end

    assign status = pend;
    assign irq    = |pend;

    // R8
    irq_on_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_in) |=> irq);

    // R10
    cause_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_in) |=> ((pend & $past(cause_in)) == $past(cause_in)));

    // R9
    clear_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && seen && cause_in == '0) |=> ((pend & $past(shown)) == '0));

endmodule

// File: rtl/host_regif.sv
module host_regif
    import hrif_pkg::*;
#(
    parameter int AW = HRIF_ADDR_W,
    parameter int DW = HRIF_DATA_W,
    parameter int NC = HRIF_CAUSES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_style,
    input  logic          cs_n,
    input  logic          strb_a,
    input  logic          strb_b,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    input  logic [NC-1:0] cause_in,
    output logic          irq
);

    localparam logic [AW-1:0] IRR_ADDR = AW'(HRIF_IRR_IDX);

    bus_style_e    style;
    ctl_pins_t     pins;
    logic          rd_act, rd_end, wr_fire;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data, scratch_q, rd_mux;
    logic [NC-1:0] status;

    assign style = bus_style_e'(bus_style);
    assign pins  = '{cs_n: cs_n, pin_a: strb_a, pin_b: strb_b};

    hrif_strobe_decode #(.AW(AW), .DW(DW)) u_decode (
        .clk(clk), .rst_n(rst_n), .style(style), .pins(pins),
        .addr(addr), .wdata(data_in),
        .rd_act(rd_act), .rd_end(rd_end),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    hrif_scratch #(.AW(AW), .DW(DW)) u_scratch (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_fire && wr_addr != IRR_ADDR),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(addr), .rd_data(scratch_q)
    );

    hrif_irq_status #(.NC(NC)) u_irq (
        .clk(clk), .rst_n(rst_n), .cause_in(cause_in),
        .rd_sel(rd_act && addr == IRR_ADDR), .rd_end(rd_end),
        .status(status), .irq(irq)
    );

    always_comb begin
        rd_mux   = (addr == IRR_ADDR) ? {{(DW-NC){1'b0}}, status} : scratch_q;
        data_oe  = rd_act;
        data_out = data_oe ? rd_mux : '0;
    end

    // R2
    oe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !cs_n);

    // R7
    irr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && addr == IRR_ADDR) |-> data_out[DW-1:NC] == '0);

endmodule

// File: tb/tb_host_regif.sv
module tb_host_regif;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_style;
    logic       cs_n, strb_a, strb_b;
    logic [2:0] addr;
    logic [7:0] data_in;
    logic [7:0] data_out;
    logic       data_oe;
    logic [3:0] cause_in;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural expectations
    logic [3:0] model_irr = '0;
    int         model_reg [8];
    logic       exp_oe = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    host_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n),
        .strb_a(strb_a), .strb_b(strb_b), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .cause_in(cause_in), .irq(irq)
    );

    task automatic ck(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // advance one clock, then compare outputs to the model mid-cycle
    task automatic step();
        @(posedge clk);
        #(CLK_P/2);
        if (rst_n) begin
            ck(irq === (model_irr != 0), "R8 irq", irq, model_irr != 0);
            ck(data_oe === exp_oe, "R2 oe", data_oe, exp_oe);
            if (!exp_oe) ck(data_out === 8'h00, "R2 idle data", data_out, 0);
        end
    endtask

    task automatic idle_pins();
        cs_n = 1'b1;
        strb_b = 1'b1;
        strb_a = bus_style ? 1'b1 : 1'b0;
    endtask

    task automatic set_style(input logic s);
        bus_style = s;
        idle_pins();
        step();
    endtask

    task automatic do_write(input int a, input int d, input bit sel);
        cs_n = !sel;
        addr = 3'(a);
        data_in = 8'(d);
        strb_a = 1'b1;
        strb_b = 1'b0;
        exp_oe = 1'b0;
        step();
        step();
        idle_pins();
        if (sel && a != 0) model_reg[a] = d & 255;
        step();
    endtask

    task automatic do_read(input int a, input logic [3:0] end_ev, input string tag,
                           output logic [7:0] got);
        int exp;
        cs_n = 1'b0;
        addr = 3'(a);
        strb_a = bus_style ? 1'b0 : 1'b1;
        strb_b = 1'b1;
        exp_oe = 1'b1;
        step();
        exp = (a == 0) ? int'(model_irr) : model_reg[a];
        ck(data_out === 8'(exp), tag, data_out, exp);
        step();
        got = data_out;
        ck(data_out === 8'(exp), tag, data_out, exp);
        idle_pins();
        exp_oe = 1'b0;
        cause_in = end_ev;
        if (a == 0) model_irr = model_irr & ~got[3:0];
        model_irr = model_irr | end_ev;
        step();
        cause_in = '0;
    endtask

    task automatic pulse_cause(input logic [3:0] b);
        cause_in = b;
        model_irr = model_irr | b;
        step();
        cause_in = '0;
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 8; i++) model_reg[i] = 0;
        rst_n = 1'b0;
        bus_style = 1'b0;
        addr = '0;
        data_in = '0;
        cause_in = '0;
        idle_pins();
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset contents, read in strobe style
        for (int i = 0; i < 8; i++) do_read(i, 4'h0, "R1 reset value", v);

        // R4: split-strobe writes, read back in strobe style (R6)
        set_style(1'b1);
        for (int i = 1; i < 8; i++) do_write(i, (i * 37 + 5) & 255, 1'b1);
        set_style(1'b0);
        for (int i = 1; i < 8; i++) do_read(i, 4'h0, "R4 split write readback", v);

        // R3: strobe-style writes, read back in split style (R6)
        for (int i = 1; i < 8; i++) do_write(i, (i * 91 + 200) & 255, 1'b1);
        set_style(1'b1);
        for (int i = 1; i < 8; i++) do_read(i, 4'h0, "R3 strobe write readback", v);

        // R6: register 0 ignores writes in both styles
        do_write(0, 8'hFF, 1'b1);
        do_read(0, 4'h0, "R6 reg0 read-only split", v);
        set_style(1'b0);
        do_write(0, 8'hF7, 1'b1);
        do_read(0, 4'h0, "R6 reg0 read-only strobe", v);

        // R5: deselected write in both styles leaves register 3 alone
        do_write(3, 8'h5A, 1'b0);
        do_read(3, 4'h0, "R5 no write without select", v);
        set_style(1'b1);
        do_write(5, 8'hC3, 1'b0);
        do_read(5, 4'h0, "R5 no write without select split", v);

        // R7: each cause sets its own bit, cleared by the read (R9)
        for (int b = 0; b < 4; b++) begin
            pulse_cause(4'(1 << b));
            step();
            do_read(0, 4'h0, "R7 cause bit map", v);
            ck(v === 8'(1 << b), "R7 single cause", v, 1 << b);
        end

        // R9: combined causes read and cleared together
        set_style(1'b0);
        pulse_cause(4'b0100);
        step();
        pulse_cause(4'b0001);
        do_read(0, 4'h0, "R9 combined read", v);
        ck(v === 8'h05, "R9 combined value", v, 5);
        ck(irq === 1'b0, "R9 irq low after read", irq, 0);

        // R10: cause on closing edge survives the clear
        pulse_cause(4'b0010);
        do_read(0, 4'b1000, "R10 read before late cause", v);
        ck(v === 8'h02, "R10 shown value", v, 2);
        ck(irq === 1'b1, "R10 irq kept", irq, 1);
        do_read(0, 4'h0, "R10 late cause visible", v);
        ck(v === 8'h08, "R10 late cause value", v, 8);

        // R8: repeated cause keeps sticky bit, irq stays high
        pulse_cause(4'b1001);
        pulse_cause(4'b0001);
        step();
        ck(irq === 1'b1, "R8 irq held", irq, 1);
        set_style(1'b1);
        do_read(0, 4'h0, "R8 sticky read", v);
        ck(v === 8'h09, "R8 sticky value", v, 9);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule